// File: doc/BRIEF.md
# Virtual List-Register Completion Engine

This block is the guest-facing side of a virtual CPU interface in a virtualization-capable interrupt controller. A hypervisor fills a small bank of list registers. Each entry carries a virtual ID, a two-bit state (pending, active, or both), a priority of which only the upper bits are stored, a hardware-link flag and a linked physical ID. The engine scans the bank for the most urgent pending entry and raises a virtual IRQ when that entry beats the running priority. It then serves the guest's acknowledge, end-of-interrupt and deactivate writes. It keeps a virtual active-priority bit vector and a wrapping completion counter.

An end-of-interrupt or deactivate write may name an ID that no entry holds as active. Such a write is not simply discarded. Depending on the completion mode, it can still drop the running priority, advance the counter, or both. When the active state of a hardware-linked entry is cleared, the block emits a one-cycle request to deactivate the linked physical interrupt.

In any one cycle only one guest operation is served, in the order acknowledge, then end-of-interrupt, then deactivate. A hypervisor list-register load in the same cycle is applied last and overrides that entry.

Top module: `vlr_eoi_engine`

## Requirements
- R1: After reset every entry is empty, `virq` and `hw_deact_valid` are 0, `eoi_count` is 0, `running_prio` is 8'hFF and `ack_vid` reads the spurious ID 1023.
- R2: Only entries in state 2'b01 (pending only; state bit 0 = pending, bit 1 = active) are candidates. The candidate with the numerically lowest stored 5-bit priority wins, and `best_prio` is that stored value shifted left by 3 (8'hFF when there is no candidate).
- R3: When candidates share the lowest priority, the lowest list-register index wins.
- R4: `virq` is 1 only when a candidate exists and its stored priority is strictly below the group of the running priority (or no priority is active). `ack_vid` shows the winner's virtual ID while `virq` is 1, and 1023 otherwise.
- R5: An acknowledge while `virq` is 1 moves the winner from pending to active on the clock edge and sets the active-priority bit indexed by its stored priority. `running_prio` is the lowest set bit index shifted left by 3, or 8'hFF when no bit is set. An acknowledge while `virq` is 0 changes nothing.
- R6: In mode 0, an end-of-interrupt naming an active entry clears the lowest set active-priority bit (if any) and clears that entry's active bit (2'b10 becomes 2'b00, 2'b11 becomes 2'b01). The counter is unchanged.
- R7: In mode 0, an end-of-interrupt naming no active entry clears the lowest active-priority bit and adds one to the counter when some bit is set, and otherwise does nothing.
- R8: In mode 0, every deactivate write is ignored, whether or not its ID is valid.
- R9: When the active bit of an entry with the hardware-link flag is cleared, `hw_deact_valid` is 1 for exactly the cycle after the write edge, with `hw_deact_pid` equal to that entry's physical ID.
- R10: In mode 1, a valid end-of-interrupt only drops priority and leaves the entry active. A valid deactivate clears the entry's active bit.
- R11: In mode 1, an invalid end-of-interrupt drops priority when a bit is set but never counts. An invalid deactivate adds one to the counter.
- R12: `eoi_count` is 5 bits wide and wraps from 31 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eoi_mode | input | 1 | 0: completion also deactivates; 1: split drop and deactivate |
| lr_wr_en | input | 1 | Hypervisor list-register load strobe |
| lr_wr_idx | input | 2 | Entry index to load |
| lr_wr_vid | input | 10 | Virtual ID to load |
| lr_wr_state | input | 2 | State to load (bit0 pending, bit1 active) |
| lr_wr_prio | input | 5 | Upper priority bits to load |
| lr_wr_hw | input | 1 | Hardware-link flag to load |
| lr_wr_pid | input | 10 | Linked physical ID to load |
| lr_rd_idx | input | 2 | Entry index for state readback |
| lr_rd_state | output | 2 | State of the selected entry |
| ack_req | input | 1 | Guest acknowledge strobe |
| ack_vid | output | 10 | ID returned by an acknowledge (1023 when none) |
| virq | output | 1 | Virtual interrupt request to the guest |
| best_prio | output | 8 | Full priority of the best candidate |
| running_prio | output | 8 | Current running priority |
| eoi_wr | input | 1 | Guest end-of-interrupt write strobe |
| eoi_vid | input | 10 | ID written with end-of-interrupt |
| dir_wr | input | 1 | Guest deactivate write strobe |
| dir_vid | input | 10 | ID written with deactivate |
| eoi_count | output | 5 | Wrapping completion counter |
| hw_deact_valid | output | 1 | Physical deactivate request pulse |
| hw_deact_pid | output | 10 | Physical ID for the deactivate request |

## Verification
On every cycle, the properties confirm four things. A raised `virq` always has a better priority than the running one. The counter only ever steps by one, and only after a completion or deactivate write. A physical deactivate pulse always follows such a write. Mode-0 deactivate writes and acknowledges made without a request leave the visible state alone. The scenarios must show the rest: which entry wins a scan, the mode-dependent handling of valid and invalid IDs, the exact state each entry moves to, and the wrap of the counter. These depend on sequences of loads and writes, not on relations within a single cycle.

// File: rtl/vlr_pkg.sv
package vlr_pkg;
    localparam int NUM_LR = 4;
    localparam int VID_W  = 10;
    localparam int PID_W  = 10;
    localparam int PRIO_W = 8;
    localparam int LRP_W  = 5;
    localparam int CNT_W  = 5;

    localparam int IDX_W  = $clog2(NUM_LR);
    localparam int APR_W  = 1 << LRP_W;
    localparam int SHIFT  = PRIO_W - LRP_W;

    localparam logic [VID_W-1:0] SPURIOUS_VID = '1;
    localparam logic [1:0] ST_PEND = 2'b01;
    localparam logic [1:0] ST_ACT  = 2'b10;

    typedef struct packed {
        logic [VID_W-1:0] vid;
        logic [PID_W-1:0] pid;
        logic             hw;
        logic [LRP_W-1:0] prio;
        logic [1:0]       st;
    } lr_t;

    typedef struct packed {
        lr_t [NUM_LR-1:0] lr;
        logic [APR_W-1:0] apr;
        logic [CNT_W-1:0] cnt;
        logic             hw_v;
        logic [PID_W-1:0] hw_pid;
    } core_t;
endpackage

// File: rtl/vlr_pick.sv
module vlr_pick #(
    parameter int N  = 4,
    parameter int PW = 5,
    parameter int IW = 2
) (
    input  logic [N-1:0]         cand,
    input  logic [N-1:0][PW-1:0] prio,
    output logic                 found,
    output logic [IW-1:0]        idx,
    output logic [PW-1:0]        best
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '1;
        for (int i = 0; i < N; i++) begin
            // strict compare keeps the lower index on a tie
            if (cand[i] && (!found || prio[i] < best)) begin
                found = 1'b1;
                idx   = IW'(i);
                best  = prio[i];
            end
        end
    end
endmodule

// File: rtl/vlr_match.sv
module vlr_match #(
    parameter int N  = 4,
    parameter int KW = 10,
    parameter int IW = 2
) (
    input  logic [N-1:0]         act,
    input  logic [N-1:0][KW-1:0] key_tab,
    input  logic [KW-1:0]        key,
    output logic                 hit,
    output logic [IW-1:0]        idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (act[i] && key_tab[i] == key) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/vlr_lowbit.sv
module vlr_lowbit #(
    parameter int W  = 32,
    parameter int IW = 5
) (
    input  logic [W-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/vlr_eoi_engine.sv
module vlr_eoi_engine
    import vlr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eoi_mode,
    input  logic             lr_wr_en,
    input  logic [IDX_W-1:0] lr_wr_idx,
    input  logic [VID_W-1:0] lr_wr_vid,
    input  logic [1:0]       lr_wr_state,
    input  logic [LRP_W-1:0] lr_wr_prio,
    input  logic             lr_wr_hw,
    input  logic [PID_W-1:0] lr_wr_pid,
    input  logic [IDX_W-1:0] lr_rd_idx,
    output logic [1:0]       lr_rd_state,
    input  logic             ack_req,
    output logic [VID_W-1:0] ack_vid,
    output logic             virq,
    output logic [PRIO_W-1:0] best_prio,
    output logic [PRIO_W-1:0] running_prio,
    input  logic             eoi_wr,
    input  logic [VID_W-1:0] eoi_vid,
    input  logic             dir_wr,
    input  logic [VID_W-1:0] dir_vid,
    output logic [CNT_W-1:0] eoi_count,
    output logic             hw_deact_valid,
    output logic [PID_W-1:0] hw_deact_pid
);
    core_t q, d;

    logic [NUM_LR-1:0]            cand_vec, act_vec;
    logic [NUM_LR-1:0][LRP_W-1:0] prio_tab;
    logic [NUM_LR-1:0][VID_W-1:0] vid_tab;

    for (genvar g = 0; g < NUM_LR; g++) begin : g_lr
        assign cand_vec[g] = (q.lr[g].st == ST_PEND);
        assign act_vec[g]  = q.lr[g].st[1];
        assign prio_tab[g] = q.lr[g].prio;
        assign vid_tab[g]  = q.lr[g].vid;
    end

    logic             pick_found;
    logic [IDX_W-1:0] pick_idx;
    logic [LRP_W-1:0] pick_prio;
    logic             apr_any;
    logic [LRP_W-1:0] apr_low;
    logic             eoi_hit, dir_hit;
    logic [IDX_W-1:0] eoi_idx, dir_idx;

    vlr_pick #(.N(NUM_LR), .PW(LRP_W), .IW(IDX_W)) u_pick (
        .cand(cand_vec), .prio(prio_tab),
        .found(pick_found), .idx(pick_idx), .best(pick_prio)
    );

    vlr_lowbit #(.W(APR_W), .IW(LRP_W)) u_apr (
        .vec(q.apr), .any(apr_any), .idx(apr_low)
    );

    vlr_match #(.N(NUM_LR), .KW(VID_W), .IW(IDX_W)) u_eoi_match (
        .act(act_vec), .key_tab(vid_tab), .key(eoi_vid),
        .hit(eoi_hit), .idx(eoi_idx)
    );

    vlr_match #(.N(NUM_LR), .KW(VID_W), .IW(IDX_W)) u_dir_match (
        .act(act_vec), .key_tab(vid_tab), .key(dir_vid),
        .hit(dir_hit), .idx(dir_idx)
    );

    logic             virq_c;
    logic             deact_en;
    logic [IDX_W-1:0] deact_idx;

    assign virq_c = pick_found && (!apr_any || pick_prio < apr_low);

    always_comb begin
        d        = q;
        d.hw_v   = 1'b0;
        deact_en = 1'b0;
        deact_idx = '0;

        if (ack_req) begin
            if (virq_c) begin
                // mark active first, then retire pending: entry never vanishes
                d.lr[pick_idx].st = d.lr[pick_idx].st | ST_ACT;
                d.lr[pick_idx].st = d.lr[pick_idx].st & ~ST_PEND;
                d.apr[pick_prio]  = 1'b1;
            end
        end else if (eoi_wr) begin
            if (apr_any) d.apr[apr_low] = 1'b0;
            if (eoi_hit) begin
                if (!eoi_mode) begin
                    deact_en  = 1'b1;
                    deact_idx = eoi_idx;
                end
            end else if (!eoi_mode && apr_any) begin
                d.cnt = q.cnt + 1'b1;
            end
        end else if (dir_wr && eoi_mode) begin
            if (dir_hit) begin
                deact_en  = 1'b1;
                deact_idx = dir_idx;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end

        if (deact_en) begin
            d.lr[deact_idx].st = q.lr[deact_idx].st & ~ST_ACT;
            if (q.lr[deact_idx].hw) begin
                d.hw_v   = 1'b1;
                d.hw_pid = q.lr[deact_idx].pid;
            end
        end

        if (lr_wr_en) begin
            d.lr[lr_wr_idx].vid  = lr_wr_vid;
            d.lr[lr_wr_idx].pid  = lr_wr_pid;
            d.lr[lr_wr_idx].hw   = lr_wr_hw;
            d.lr[lr_wr_idx].prio = lr_wr_prio;
            d.lr[lr_wr_idx].st   = lr_wr_state;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign virq           = virq_c;
    assign ack_vid        = virq_c ? q.lr[pick_idx].vid : SPURIOUS_VID;
    assign best_prio      = pick_found ? {pick_prio, {SHIFT{1'b0}}} : '1;
    assign running_prio   = apr_any ? {apr_low, {SHIFT{1'b0}}} : '1;
    assign lr_rd_state    = q.lr[lr_rd_idx].st;
    assign eoi_count      = q.cnt;
    assign hw_deact_valid = q.hw_v;
    assign hw_deact_pid   = q.hw_pid;
endmodule

// File: rtl/vlr_eoi_engine_chk.sv
module vlr_eoi_engine_chk
    import vlr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              eoi_mode,
    input logic              ack_req,
    input logic              eoi_wr,
    input logic              dir_wr,
    input logic              virq,
    input logic [PRIO_W-1:0] best_prio,
    input logic [PRIO_W-1:0] running_prio,
    input logic [CNT_W-1:0]  eoi_count,
    input logic              hw_deact_valid
);
    assert_virq_beats_running_R4: assert property (@(posedge clk) disable iff (!rst_n)
        virq |-> best_prio < running_prio);

    assert_count_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_count != $past(eoi_count)) |-> (eoi_count == $past(eoi_count) + 5'd1));

    assert_count_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_count != $past(eoi_count)) |-> ($past(eoi_wr) || $past(dir_wr)));

    assert_hw_pulse_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hw_deact_valid |-> ($past(eoi_wr) || $past(dir_wr)));

    assert_dir_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_wr && !eoi_mode && !ack_req && !eoi_wr) |=>
            ($stable(eoi_count) && $stable(running_prio) && !hw_deact_valid));

    assert_idle_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !virq) |=> $stable(running_prio));
endmodule

bind vlr_eoi_engine vlr_eoi_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .eoi_mode(eoi_mode), .ack_req(ack_req),
    .eoi_wr(eoi_wr), .dir_wr(dir_wr), .virq(virq), .best_prio(best_prio),
    .running_prio(running_prio), .eoi_count(eoi_count),
    .hw_deact_valid(hw_deact_valid)
);

// File: tb/vlr_eoi_engine_tb.sv
module vlr_eoi_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NROW = 6;
    localparam logic [4:0] PTAB [NROW][4] = '{
        '{5'd3,  5'd7,  5'd9,  5'd2},
        '{5'd5,  5'd5,  5'd5,  5'd5},
        '{5'd31, 5'd30, 5'd30, 5'd31},
        '{5'd0,  5'd0,  5'd1,  5'd1},
        '{5'd8,  5'd4,  5'd4,  5'd8},
        '{5'd9,  5'd9,  5'd9,  5'd1}
    };
    localparam int EXP_IDX [NROW] = '{3, 0, 1, 0, 1, 3};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic eoi_mode = 1'b0;
    logic lr_wr_en = 1'b0;
    logic [1:0] lr_wr_idx = '0;
    logic [9:0] lr_wr_vid = '0;
    logic [1:0] lr_wr_state = '0;
    logic [4:0] lr_wr_prio = '0;
    logic lr_wr_hw = 1'b0;
    logic [9:0] lr_wr_pid = '0;
    logic [1:0] lr_rd_idx = '0;
    logic [1:0] lr_rd_state;
    logic ack_req = 1'b0;
    logic [9:0] ack_vid;
    logic virq;
    logic [7:0] best_prio, running_prio;
    logic eoi_wr = 1'b0;
    logic [9:0] eoi_vid = '0;
    logic dir_wr = 1'b0;
    logic [9:0] dir_vid = '0;
    logic [4:0] eoi_count;
    logic hw_deact_valid;
    logic [9:0] hw_deact_pid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vlr_eoi_engine u_dut (
        .clk(clk), .rst_n(rst_n), .eoi_mode(eoi_mode),
        .lr_wr_en(lr_wr_en), .lr_wr_idx(lr_wr_idx), .lr_wr_vid(lr_wr_vid),
        .lr_wr_state(lr_wr_state), .lr_wr_prio(lr_wr_prio), .lr_wr_hw(lr_wr_hw),
        .lr_wr_pid(lr_wr_pid), .lr_rd_idx(lr_rd_idx), .lr_rd_state(lr_rd_state),
        .ack_req(ack_req), .ack_vid(ack_vid), .virq(virq), .best_prio(best_prio),
        .running_prio(running_prio), .eoi_wr(eoi_wr), .eoi_vid(eoi_vid),
        .dir_wr(dir_wr), .dir_vid(dir_vid), .eoi_count(eoi_count),
        .hw_deact_valid(hw_deact_valid), .hw_deact_pid(hw_deact_pid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic lr_load(input logic [1:0] idx, input logic [9:0] vid, input logic [1:0] st,
                           input logic [4:0] prio, input logic hw, input logic [9:0] pid);
        lr_wr_en = 1'b1; lr_wr_idx = idx; lr_wr_vid = vid; lr_wr_state = st;
        lr_wr_prio = prio; lr_wr_hw = hw; lr_wr_pid = pid;
        @(negedge clk);
        lr_wr_en = 1'b0;
    endtask

    task automatic clear_all();
        for (int i = 0; i < 4; i++) lr_load(2'(i), 10'd0, 2'b00, 5'd0, 1'b0, 10'd0);
    endtask

    task automatic do_ack();
        ack_req = 1'b1; @(negedge clk); ack_req = 1'b0;
    endtask

    task automatic do_eoi(input logic [9:0] vid);
        eoi_wr = 1'b1; eoi_vid = vid; @(negedge clk); eoi_wr = 1'b0;
    endtask

    task automatic do_dir(input logic [9:0] vid);
        dir_wr = 1'b1; dir_vid = vid; @(negedge clk); dir_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] idx, output logic [1:0] st);
        lr_rd_idx = idx; #1; st = lr_rd_state;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [1:0] st;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 virq", virq, 0);
        chk("R1 count", eoi_count, 0);
        chk("R1 running", running_prio, 8'hFF);
        chk("R1 hw pulse", hw_deact_valid, 0);
        chk("R1 ack id", ack_vid, 10'd1023);
        rd(2'd2, st); chk("R1 entry empty", st, 2'b00);

        // R2/R3 candidate table
        for (int r = 0; r < NROW; r++) begin
            for (int i = 0; i < 4; i++) lr_load(2'(i), 10'(10 + i), 2'b01, PTAB[r][i], 1'b0, 10'd0);
            chk("R2 R3 winner", ack_vid, 32'(10 + EXP_IDX[r]));
            chk("R2 shifted prio", best_prio, {24'd0, PTAB[r][EXP_IDX[r]], 3'b000});
            chk("R4 virq idle", virq, 1);
        end
        clear_all();
        chk("R2 no candidate", best_prio, 8'hFF);

        // R4/R5 acknowledge
        lr_load(2'd0, 10'd33, 2'b01, 5'd4, 1'b1, 10'd77);
        chk("R4 virq", virq, 1);
        chk("R4 ack id", ack_vid, 10'd33);
        do_ack();
        rd(2'd0, st); chk("R5 active", st, 2'b10);
        chk("R5 running", running_prio, 8'h20);
        chk("R4 virq off", virq, 0);
        chk("R4 spurious", ack_vid, 10'd1023);
        do_ack();
        chk("R5 idle ack running", running_prio, 8'h20);
        rd(2'd0, st); chk("R5 idle ack state", st, 2'b10);

        lr_load(2'd1, 10'd40, 2'b01, 5'd6, 1'b0, 10'd0);
        chk("R4 masked", virq, 0);
        lr_load(2'd2, 10'd41, 2'b01, 5'd2, 1'b0, 10'd0);
        chk("R4 preempt", virq, 1);
        chk("R4 preempt id", ack_vid, 10'd41);
        lr_load(2'd1, 10'd0, 2'b00, 5'd0, 1'b0, 10'd0);
        lr_load(2'd2, 10'd0, 2'b00, 5'd0, 1'b0, 10'd0);

        // R6/R9 mode 0 valid completion of hw entry
        eoi_mode = 1'b0;
        do_eoi(10'd33);
        chk("R9 pulse", hw_deact_valid, 1);
        chk("R9 pid", hw_deact_pid, 10'd77);
        rd(2'd0, st); chk("R6 deactivated", st, 2'b00);
        chk("R6 drop", running_prio, 8'hFF);
        chk("R6 no count", eoi_count, 0);
        @(negedge clk);
        chk("R9 one cycle", hw_deact_valid, 0);

        // R7 invalid completion, nothing active
        do_eoi(10'd500);
        chk("R7 no count", eoi_count, 0);
        chk("R7 running", running_prio, 8'hFF);

        // R7 invalid with active priority, R8 deactivate ignored
        lr_load(2'd0, 10'd50, 2'b01, 5'd8, 1'b0, 10'd0);
        do_ack();
        chk("R5 running 40", running_prio, 8'h40);
        do_eoi(10'd500);
        chk("R7 drop", running_prio, 8'hFF);
        chk("R7 count", eoi_count, 1);
        rd(2'd0, st); chk("R7 entry kept", st, 2'b10);
        do_dir(10'd500);
        chk("R8 invalid dir", eoi_count, 1);
        do_dir(10'd50);
        rd(2'd0, st); chk("R8 valid dir", st, 2'b10);
        do_eoi(10'd50);
        rd(2'd0, st); chk("R6 no prio", st, 2'b00);
        chk("R6 count kept", eoi_count, 1);

        // R10 mode 1 split
        eoi_mode = 1'b1;
        lr_load(2'd1, 10'd60, 2'b01, 5'd1, 1'b1, 10'd99);
        do_ack();
        chk("R5 running 08", running_prio, 8'h08);
        do_eoi(10'd60);
        chk("R10 drop", running_prio, 8'hFF);
        rd(2'd1, st); chk("R10 still active", st, 2'b10);
        chk("R10 no pulse", hw_deact_valid, 0);
        do_dir(10'd60);
        rd(2'd1, st); chk("R10 dir clears", st, 2'b00);
        chk("R9 pulse m1", hw_deact_valid, 1);
        chk("R9 pid m1", hw_deact_pid, 10'd99);
        chk("R10 count", eoi_count, 1);

        // R11 mode 1 invalid
        do_dir(10'd700);
        chk("R11 dir count", eoi_count, 2);
        lr_load(2'd2, 10'd61, 2'b01, 5'd3, 1'b0, 10'd0);
        do_ack();
        do_eoi(10'd700);
        chk("R11 eoi drop", running_prio, 8'hFF);
        chk("R11 eoi no count", eoi_count, 2);
        lr_load(2'd2, 10'd0, 2'b00, 5'd0, 1'b0, 10'd0);

        // R12 wrap
        for (int k = 0; k < 29; k++) do_dir(10'd700);
        chk("R12 max", eoi_count, 31);
        do_dir(10'd700);
        chk("R12 wrap", eoi_count, 0);

        // R2/R6 active-and-pending entry
        eoi_mode = 1'b0;
        lr_load(2'd3, 10'd70, 2'b11, 5'd5, 1'b0, 10'd0);
        chk("R2 active excluded", virq, 0);
        do_eoi(10'd70);
        rd(2'd3, st); chk("R6 keeps pending", st, 2'b01);
        chk("R4 repend virq", virq, 1);
        chk("R4 repend id", ack_vid, 10'd70);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule